// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches host bus writes to a byte-wide flash and decides which array operation, if any, they request. Each write arrives as a one-cycle strobe. The strobe already carries the address and data that the edge rules resolved: the address taken on the later falling edge of the write and chip enables, the data on the earlier rising edge.

Writes that alter the array are accepted only after an exact unlock pattern. The decoder recognises these sequences:
- byte program
- sector erase
- chip erase
- entry to identification mode
- exit from identification mode

Any write that breaks the expected pattern drops the decoder back to plain read without side effects.

A recognised operation leaves the block as a one-cycle request pulse, with the latched address and data, to a separate busy/array model. That model returns a busy level. While busy is high, every write is ignored. A level output marks identification mode. In that mode a small read decoder supplies the fixed identification bytes for the read address.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, and whenever `rst_n` is low, no request is active, `id_mode` is 0 and `id_byte` is 00H.
- R2: A write is taken only in a cycle where `wr_stb` is 1, `ce_n` is 0 and `oe_n` is 1. A strobe with `ce_n` high, with `oe_n` low, or no strobe at all changes nothing.
- R3: The cycles AAH at 5555H, then 55H at 2AAAH, then A0H at 5555H, followed by one write of any address and data, give `prog_req` for exactly one cycle. The pulse comes in the cycle after that fourth write, with `op_addr`/`op_data` equal to that write. Unlock addresses are matched on the low 15 address bits only.
- R4: The cycles AAH/5555H, 55H/2AAAH, 80H/5555H, AAH/5555H, 55H/2AAAH, then 30H at any address, give a one-cycle `serase_req`. With it, `op_addr` carries the written address with its low SECT_BITS bits cleared (the 4 KB sector base), and `op_data` is 30H.
- R5: The same five-cycle prefix as in R4, followed by 10H written at 5555H, gives a one-cycle `cerase_req` with `op_data` = 10H.
- R6: A taken write that does not match the cycle the sequence expects returns the decoder to read mode with no request. A 10H sixth cycle at any address other than 5555H is such a mismatch. The mismatching write is itself discarded: it does not start a new sequence, even when it is AAH at 5555H.
- R7: The command byte 90H in the third cycle sets `id_mode`, and F0H there clears it. Any other third-cycle byte except A0H and 80H aborts and leaves `id_mode` unchanged.
- R8: While `id_mode` is 1, `id_byte` is MFR_ID (BFH) for `rd_addr` 0, DEV_ID (default B7H) for `rd_addr` 1, and 00H for every other address. While `id_mode` is 0, `id_byte` is 00H. The output is combinational in `rd_addr`.
- R9: Writes made while `busy_i` is 1 are ignored, including the identification exit. The partly entered sequence is kept and continues once `busy_i` falls.
- R10: At most one of `prog_req`, `serase_req` and `cerase_req` is 1 in any cycle, and none stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle bus write strobe |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| wr_addr | input | AW | Resolved write address |
| wr_data | input | 8 | Resolved write data |
| busy_i | input | 1 | Internal program or erase in progress |
| rd_addr | input | AW | Read address for the identification bytes |
| prog_req | output | 1 | Byte program request pulse |
| serase_req | output | 1 | Sector erase request pulse |
| cerase_req | output | 1 | Chip erase request pulse |
| op_addr | output | AW | Address latched with the last request |
| op_data | output | 8 | Data latched with the last request |
| id_mode | output | 1 | Identification mode active |
| id_byte | output | 8 | Identification byte for `rd_addr` |

## Verification
The bench builds the decoder with AW = 16 and the default 12-bit sector offset. With that setting every one of the 16 sectors can be erased, and the first 1024 read addresses can be swept in identification mode. All 256 third-cycle command bytes are swept, with the expected mode held in a bench model. An abort is injected at each position of the program and erase sequences, on both address and data. Bit 15 lies just above the compared unlock field, so unlock addresses with bit 15 set show that only the low 15 bits are matched.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW = 19,
  parameter int CMD_BITS = 15,
  parameter int SECT_BITS = 12,
  parameter logic [7:0] MFR_ID = 8'hBF,
  parameter logic [7:0] DEV_ID = 8'hB7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          busy_i,
  input  logic [AW-1:0] rd_addr,
  output logic          prog_req,
  output logic          serase_req,
  output logic          cerase_req,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          id_mode,
  output logic [7:0]    id_byte
);
  localparam logic [CMD_BITS-1:0] KEY_A = CMD_BITS'(16'h5555);
  localparam logic [CMD_BITS-1:0] KEY_B = CMD_BITS'(16'h2AAA);

  typedef enum logic [2:0] {S_IDLE, S_K1, S_K2, S_PROG, S_E3, S_E4, S_E5} st_t;

  st_t  st, nxt;
  logic go_p, go_s, go_c, id_set, id_clr;

  wire take = wr_stb & ~ce_n & oe_n & ~busy_i;
  wire at_a = wr_addr[CMD_BITS-1:0] == KEY_A;
  wire at_b = wr_addr[CMD_BITS-1:0] == KEY_B;
  wire key1 = at_a && wr_data == 8'hAA;
  wire key2 = at_b && wr_data == 8'h55;

  always_comb begin
    nxt = st;
    go_p = 1'b0;
    go_s = 1'b0;
    go_c = 1'b0;
    id_set = 1'b0;
    id_clr = 1'b0;
    if (take) begin
      case (st)
        S_IDLE: nxt = key1 ? S_K1 : S_IDLE;
        S_K1:   nxt = key2 ? S_K2 : S_IDLE;
        S_K2: begin
          nxt = S_IDLE;
          if (at_a) begin
            case (wr_data)
              8'hA0: nxt = S_PROG;
              8'h80: nxt = S_E3;
              8'h90: id_set = 1'b1;
              8'hF0: id_clr = 1'b1;
              default: ;
            endcase
          end
        end
        S_PROG: begin
          nxt = S_IDLE;
          go_p = 1'b1;
        end
        S_E3: nxt = key1 ? S_E4 : S_IDLE;
        S_E4: nxt = key2 ? S_E5 : S_IDLE;
        S_E5: begin
          nxt = S_IDLE;
          if (wr_data == 8'h30) go_s = 1'b1;
          else if (wr_data == 8'h10 && at_a) go_c = 1'b1;
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      prog_req <= 1'b0;
      serase_req <= 1'b0;
      cerase_req <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
      id_mode <= 1'b0;
    end else begin
      st <= nxt;
      prog_req <= go_p;
      serase_req <= go_s;
      cerase_req <= go_c;
      if (go_p | go_c) op_addr <= wr_addr;
      else if (go_s) op_addr <= {wr_addr[AW-1:SECT_BITS], SECT_BITS'(0)};
      if (go_p | go_s | go_c) op_data <= wr_data;
      if (id_set) id_mode <= 1'b1;
      else if (id_clr) id_mode <= 1'b0;
    end
  end

  assign id_byte = !id_mode ? 8'h00 :
                   rd_addr == '0 ? MFR_ID :
                   rd_addr == AW'(1) ? DEV_ID : 8'h00;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int AW = 19,
  parameter int CMD_BITS = 15,
  parameter int SECT_BITS = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_stb,
  input logic          ce_n,
  input logic          oe_n,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          busy_i,
  input logic          prog_req,
  input logic          serase_req,
  input logic          cerase_req,
  input logic [AW-1:0] op_addr,
  input logic [7:0]    op_data,
  input logic          id_mode
);
  localparam logic [CMD_BITS-1:0] KEY_A = CMD_BITS'(16'h5555);
  wire any_req = prog_req | serase_req | cerase_req;
  wire taken = wr_stb && !ce_n && oe_n;

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, serase_req, cerase_req})); // R10
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> !any_req); // R10
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> (!any_req && $stable(id_mode))); // R9
  AST_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> (!any_req && $stable(id_mode))); // R2
  AST_PROG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> (op_addr == $past(wr_addr) && op_data == $past(wr_data))); // R3
  AST_SECTOR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    serase_req |-> ($past(wr_data) == 8'h30 &&
                    op_addr[AW-1:SECT_BITS] == $past(wr_addr[AW-1:SECT_BITS]))); // R4
  AST_CHIP_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    cerase_req |-> ($past(wr_data) == 8'h10 &&
                    $past(wr_addr[CMD_BITS-1:0]) == KEY_A)); // R5
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.AW(AW), .CMD_BITS(CMD_BITS), .SECT_BITS(SECT_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .ce_n(ce_n), .oe_n(oe_n),
  .wr_addr(wr_addr), .wr_data(wr_data), .busy_i(busy_i),
  .prog_req(prog_req), .serase_req(serase_req), .cerase_req(cerase_req),
  .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0, ce_n = 1'b0, oe_n = 1'b1, busy_i = 1'b0;
  logic [15:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic prog_req, serase_req, cerase_req, id_mode;
  logic [15:0] op_addr;
  logic [7:0] op_data, id_byte;
  int total = 0, fails = 0;
  bit done = 1'b0;
  bit exp_id = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_decoder #(.AW(16)) uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .ce_n(ce_n), .oe_n(oe_n),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy_i(busy_i), .rd_addr(rd_addr),
    .prog_req(prog_req), .serase_req(serase_req), .cerase_req(cerase_req),
    .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode), .id_byte(id_byte)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_req(string tag, logic [2:0] e);
    chk(tag, 32'({prog_req, serase_req, cerase_req}), 32'(e));
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    wr_addr = a;
    wr_data = d;
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic unlock(logic [15:0] hi);
    wr(16'h5555 | hi, 8'hAA);
    wr(16'h2AAA | hi, 8'h55);
  endtask

  task automatic erase_prefix();
    unlock(16'h0);
    wr(16'h5555, 8'h80);
    unlock(16'h0);
  endtask

  initial begin
    logic [15:0] ea[6];
    logic [7:0] ed[6];
    ea = '{16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA, 16'h1000};
    ed = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
    repeat (3) @(negedge clk);
    chk_req("R1 reset requests", 3'b000);
    chk("R1 reset id_mode", 32'(id_mode), 32'd0);
    chk("R1 reset id_byte", 32'(id_byte), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 program sweep, unlock addresses with bit 15 set on odd passes
    for (int i = 0; i < 64; i++) begin
      logic [15:0] a;
      logic [7:0] d;
      a = 16'((i * 1031) & 16'hFFFF);
      d = 8'((i * 37 + 5) & 8'hFF);
      unlock(i[0] ? 16'h8000 : 16'h0);
      wr(16'h5555 | (i[0] ? 16'h8000 : 16'h0), 8'hA0);
      chk_req("R3 no request before fourth write", 3'b000);
      wr(a, d);
      chk_req("R3 program request", 3'b100);
      chk("R3 op_addr", 32'(op_addr), 32'(a));
      chk("R3 op_data", 32'(op_data), 32'(d));
      @(negedge clk);
      chk_req("R10 single-cycle pulse", 3'b000);
    end

    // R4 every sector
    for (int s = 0; s < 16; s++) begin
      logic [15:0] a;
      a = 16'((s << 12) | ((s * 773) & 12'hFFF));
      erase_prefix();
      wr(a, 8'h30);
      chk_req("R4 sector erase request", 3'b010);
      chk("R4 sector base", 32'(op_addr), 32'(s << 12));
      chk("R4 op_data", 32'(op_data), 32'h30);
    end

    // R5 chip erase, and R6 with a wrong final address
    erase_prefix();
    wr(16'h5555, 8'h10);
    chk_req("R5 chip erase request", 3'b001);
    chk("R5 op_data", 32'(op_data), 32'h10);
    erase_prefix();
    wr(16'h2AAA, 8'h10);
    chk_req("R6 chip erase at wrong address", 3'b000);

    // R6 abort at each erase position, on data then on address
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 6; k++)
        for (int j = 0; j < 6; j++) begin
          if (j == k && m == 0) wr(ea[j], ed[j] ^ 8'h01);
          else if (j == k) wr(ea[j] ^ 16'h0004, ed[j]);
          else wr(ea[j], ed[j]);
          if (k == 5 && m == 1 && j == 5) chk_req("R4 sector address may vary", 3'b010);
          else chk_req("R6 aborted erase gives no request", 3'b000);
        end

    // R6 abort at each program unlock position
    for (int k = 0; k < 3; k++) begin
      wr(k == 0 ? 16'h5555 : 16'h5555, k == 0 ? 8'hAB : 8'hAA);
      wr(16'h2AAA, k == 1 ? 8'h54 : 8'h55);
      wr(16'h5555, k == 2 ? 8'hA1 : 8'hA0);
      wr(16'h0123, 8'h5A);
      chk_req("R6 aborted program gives no request", 3'b000);
    end

    // R6 the aborting write does not restart a sequence
    wr(16'h5555, 8'hAA);
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
    wr(16'h5555, 8'hA0);
    wr(16'h0100, 8'h77);
    chk_req("R6 aborting AAH is not a restart", 3'b000);
    unlock(16'h0);
    wr(16'h5555, 8'hA0);
    wr(16'h0100, 8'h77);
    chk_req("R6 recovery after abort", 3'b100);

    // R7 every third-cycle command byte
    exp_id = 1'b0;
    for (int c = 0; c < 256; c++) begin
      unlock(16'h0);
      wr(16'h5555, 8'(c));
      if (c == 8'hA0) begin
        wr(16'(16'h0400 + c), 8'(c));
        chk_req("R3 program from command sweep", 3'b100);
      end else if (c == 8'h80) begin
        unlock(16'h0);
        wr(16'h0000, 8'h00);
        chk_req("R6 bad sixth cycle", 3'b000);
      end else begin
        chk_req("R7 command gives no request", 3'b000);
      end
      if (c == 8'h90) exp_id = 1'b1;
      if (c == 8'hF0) exp_id = 1'b0;
      chk("R7 id_mode after command", 32'(id_mode), 32'(exp_id));
    end

    // R8 identification reads
    unlock(16'h0);
    wr(16'h5555, 8'h90);
    chk("R7 id entry", 32'(id_mode), 32'd1);
    for (int r = 0; r < 1024; r++) begin
      rd_addr = 16'(r);
      #1;
      chk("R8 id_byte in id mode", 32'(id_byte), r == 0 ? 32'hBF : r == 1 ? 32'hB7 : 32'h00);
    end
    rd_addr = 16'h8001;
    #1;
    chk("R8 high address bits decoded", 32'(id_byte), 32'h00);

    // R9 busy ignores writes, including the exit
    @(negedge clk);
    busy_i = 1'b1;
    unlock(16'h0);
    wr(16'h5555, 8'hF0);
    chk("R9 exit ignored while busy", 32'(id_mode), 32'd1);
    unlock(16'h0);
    wr(16'h5555, 8'hA0);
    wr(16'h0222, 8'h11);
    chk_req("R9 program ignored while busy", 3'b000);
    busy_i = 1'b0;
    unlock(16'h0);
    busy_i = 1'b1;
    wr(16'h0333, 8'h99);
    busy_i = 1'b0;
    wr(16'h5555, 8'hA0);
    wr(16'h0333, 8'h66);
    chk_req("R9 sequence kept across busy", 3'b100);
    chk("R9 op_data", 32'(op_data), 32'h66);
    unlock(16'h0);
    wr(16'h5555, 8'hF0);
    rd_addr = 16'h0000;
    #1;
    chk("R7 id exit", 32'(id_mode), 32'd0);
    chk("R8 id_byte outside id mode", 32'(id_byte), 32'h00);

    // R2 inhibited writes
    unlock(16'h0);
    wr(16'h5555, 8'hA0);
    ce_n = 1'b1;
    wr(16'h0444, 8'h44);
    chk_req("R2 chip enable high inhibits", 3'b000);
    ce_n = 1'b0;
    oe_n = 1'b0;
    wr(16'h0444, 8'h44);
    chk_req("R2 output enable low inhibits", 3'b000);
    oe_n = 1'b1;
    @(negedge clk);
    wr_addr = 16'h0444;
    @(negedge clk);
    chk_req("R2 no strobe no write", 3'b000);
    wr(16'h0555, 8'h45);
    chk_req("R2 state kept over inhibited cycles", 3'b100);
    chk("R2 op_addr", 32'(op_addr), 32'h0555);
    ce_n = 1'b1;
    unlock(16'h0);
    wr(16'h5555, 8'h90);
    ce_n = 1'b0;
    chk("R2 inhibited id entry", 32'(id_mode), 32'd0);

    // R1 reset during id mode
    unlock(16'h0);
    wr(16'h5555, 8'h90);
    rst_n = 1'b0;
    #1;
    chk("R1 reset clears id_mode", 32'(id_mode), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule